// File: doc/BRIEF.md
# MSI source PQ gating engine

This block takes one message-signalled interrupt trigger at a time and decides what it does. It forms a source number from the message, then checks that number against the configured limits. If the checks pass, it reads the source's 64-bit vector entry from memory over a request/response port. The entry holds a present bit (P), a queued bit (Q), a priority, a target server, a generation value and an owner tag. The P and Q bits merge repeated triggers. A priority of 0xFF masks the source.

Depending on the PQ state it finds, the engine does one of three things. It sets P and emits an interrupt to the server. It sets Q only and emits nothing. Or it drops the event with no write. A resend path sets the force input, which makes the engine treat the stored PQ as 00. A lookup that fails raises a one-cycle error pulse and causes no write and no interrupt.

The configuration inputs must stay stable while a trigger is in flight. A read response must arrive no earlier than the cycle after the read request is accepted.

Top module: `msi_pq_gate`

## Requirements
- R1: After reset, trig_ready is high, and rd_valid, wr_valid, irq_valid and err are low.
- R2: When cfg_tbl_en is low, an accepted trigger gives one err pulse and makes no read, no write and no interrupt.
- R3: A source number not below cfg_tbl_len, or not below cfg_src_count, gives one err pulse and makes no memory access.
- R4: The source number is trig_addr[19:4] OR trig_data[4:0]. The entry is read at cfg_tbl_base + 16*src, or at cfg_tbl_base + 128*src when cfg_large is high.
- R5: When trig_chk_owner is high and entry bits 15:0 differ from trig_owner, the engine gives one err pulse and makes no write and no interrupt.
- R6: The entry is big-endian. Its fields are: server in bits 63:48, priority in bits 47:40, generation in bits 26:25, P in bit 24, Q in bit 16, owner in bits 15:0. With PQ=00 and priority not 0xFF, the engine writes the byte {5'b0, gen, 1'b1} at entry+4. It then gives a one-cycle irq_valid with server = bits 63:50, source = src + cfg_src_offset (IRQ_W bits), and the entry priority.
- R7: With PQ=00 and priority 0xFF (masked), the engine writes 0x01 at entry+5 and emits no interrupt.
- R8: PQ is {P, Q}. With PQ=10 the engine writes 0x01 at entry+5 and emits no interrupt. With PQ=01 or 11 it makes no write and emits no interrupt.
- R9: With trig_force high, the stored P and Q are ignored and the entry is handled as PQ=00.
- R10: From acceptance until the read and any write have completed, trig_ready stays low. rd_valid and wr_valid, with their address and data, hold steady until accepted. A new trigger can be accepted in the same cycle as irq_valid.
- R11: err is a single-cycle pulse, given once for each failed lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_en | input | 1 | Vector table enable |
| cfg_tbl_base | input | ADDR_W | Vector table base address |
| cfg_tbl_len | input | SRC_W+1 | Number of table entries |
| cfg_large | input | 1 | Selects 128-byte entry stride (else 16) |
| cfg_src_count | input | SRC_W+1 | Number of sources served |
| cfg_src_offset | input | IRQ_W | Added to source number in emitted interrupt |
| trig_valid | input | 1 | Trigger present |
| trig_ready | output | 1 | Engine can accept a trigger |
| trig_addr | input | ADDR_W | Message address |
| trig_data | input | 16 | Message data |
| trig_force | input | 1 | Bypass PQ state (resend) |
| trig_chk_owner | input | 1 | Compare entry owner with trig_owner |
| trig_owner | input | 16 | Expected owner tag |
| rd_valid | output | 1 | Entry read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Entry address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Entry, big-endian |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | ADDR_W | Byte address |
| wr_data | output | 8 | Byte value |
| irq_valid | output | 1 | Interrupt emitted this cycle |
| irq_server | output | 14 | Target server |
| irq_src | output | IRQ_W | Global source number |
| irq_prio | output | 8 | Interrupt priority |
| err | output | 1 | Failed-lookup pulse |

## Verification
Two events can fall in the same cycle: the emission of an interrupt and the acceptance of the next trigger. The bench provokes this by presenting a new trigger while the previous one is still in flight. The new trigger is held until trig_ready returns, and that happens in the interrupt cycle when the earlier trigger set P. Each interrupt's server, source and priority are compared with the prediction made for the earlier trigger. The following read and write are compared with the prediction for the new trigger. A counter of overlapping cycles must be non-zero.

// File: rtl/msi_pq_gate.sv
module msi_pq_gate #(
  parameter int ADDR_W = 48,
  parameter int SRC_W  = 16,
  parameter int IRQ_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tbl_en,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic [SRC_W:0]    cfg_tbl_len,
  input  logic              cfg_large,
  input  logic [SRC_W:0]    cfg_src_count,
  input  logic [IRQ_W-1:0]  cfg_src_offset,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic [15:0]       trig_data,
  input  logic              trig_force,
  input  logic              trig_chk_owner,
  input  logic [15:0]       trig_owner,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              irq_valid,
  output logic [13:0]       irq_server,
  output logic [IRQ_W-1:0]  irq_src,
  output logic [7:0]        irq_prio,
  output logic              err
);
  localparam int SMALL_SH = 4;
  localparam int LARGE_SH = 7;
  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_RDREQ, S_RDWAIT, S_DEC, S_WR, S_SEND
  } st_t;

  st_t               st;
  logic [SRC_W-1:0]  src_q;
  logic              force_q, chk_q, send_q;
  logic [15:0]       own_q;
  logic [13:0]       srv_q;
  logic [7:0]        prio_q;
  logic [1:0]        gen_q;
  logic              p_q, q_q;
  logic [15:0]       eown_q;
  logic [ADDR_W-1:0] ent_addr_q, wr_addr_q;
  logic [7:0]        wr_data_q;

  logic unused_bits;
  assign unused_bits = ^{trig_addr[ADDR_W-1:SRC_W+4], trig_addr[3:0], trig_data[15:5],
                         rsp_data[49:48], rsp_data[39:27], rsp_data[23:17]};

  wire [SRC_W-1:0]  src_in = trig_addr[SRC_W+3:4] | SRC_W'(trig_data[4:0]);
  wire              acc    = trig_valid && trig_ready;
  wire [SRC_W:0]    src_x  = {1'b0, src_q};
  wire              oob    = !cfg_tbl_en || (src_x >= cfg_tbl_len) || (src_x >= cfg_src_count);
  wire [ADDR_W-1:0] off    = cfg_large ? (ADDR_W'(src_q) << LARGE_SH) : (ADDR_W'(src_q) << SMALL_SH);
  wire [1:0]        pq     = force_q ? 2'b00 : {p_q, q_q};
  wire              own_bad = chk_q && (eown_q != own_q);

  assign trig_ready = (st == S_IDLE) || (st == S_SEND);
  assign err        = ((st == S_CHK) && oob) || ((st == S_DEC) && own_bad);
  assign rd_valid   = (st == S_RDREQ);
  assign rd_addr    = ent_addr_q;
  assign wr_valid   = (st == S_WR);
  assign wr_addr    = wr_addr_q;
  assign wr_data    = wr_data_q;
  assign irq_valid  = (st == S_SEND);
  assign irq_server = srv_q;
  assign irq_src    = cfg_src_offset + IRQ_W'(src_q);
  assign irq_prio   = prio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      src_q      <= '0;
      force_q    <= 1'b0;
      chk_q      <= 1'b0;
      send_q     <= 1'b0;
      own_q      <= '0;
      srv_q      <= '0;
      prio_q     <= '0;
      gen_q      <= '0;
      p_q        <= 1'b0;
      q_q        <= 1'b0;
      eown_q     <= '0;
      ent_addr_q <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      if (acc) begin
        src_q   <= src_in;
        force_q <= trig_force;
        chk_q   <= trig_chk_owner;
        own_q   <= trig_owner;
      end
      case (st)
        S_IDLE:  if (acc) st <= S_CHK;
        S_CHK: begin
          ent_addr_q <= cfg_tbl_base + off;
          st         <= oob ? S_IDLE : S_RDREQ;
        end
        S_RDREQ: if (rd_ready) st <= S_RDWAIT;
        S_RDWAIT: if (rsp_valid) begin
          srv_q  <= rsp_data[63:50];
          prio_q <= rsp_data[47:40];
          gen_q  <= rsp_data[26:25];
          p_q    <= rsp_data[24];
          q_q    <= rsp_data[16];
          eown_q <= rsp_data[15:0];
          st     <= S_DEC;
        end
        S_DEC: begin
          send_q <= 1'b0;
          if (own_bad) begin
            st <= S_IDLE;
          end else if (pq == 2'b00 && prio_q != PRIO_OFF) begin
            wr_addr_q <= ent_addr_q + ADDR_W'(4);
            wr_data_q <= {5'b0, gen_q, 1'b1};
            send_q    <= 1'b1;
            st        <= S_WR;
          end else if (pq == 2'b00 || pq == 2'b10) begin
            wr_addr_q <= ent_addr_q + ADDR_W'(5);
            wr_data_q <= 8'h01;
            st        <= S_WR;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WR:   if (wr_ready) st <= send_q ? S_SEND : S_IDLE;
        S_SEND: st <= acc ? S_CHK : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module msi_pq_gate_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_tbl_en,
  input logic              trig_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              irq_valid,
  input logic [7:0]        irq_prio,
  input logic              err
);
  p_rd_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cfg_tbl_en);
  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!irq_valid && !wr_valid && !rd_valid));
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  p_no_masked_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_prio != 8'hFF));
  p_wr_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[0] && wr_data[7:3] == 5'd0));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  p_busy_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !trig_ready);
  p_busy_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !trig_ready);
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind msi_pq_gate msi_pq_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tbl_en(cfg_tbl_en), .trig_ready(trig_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_valid(irq_valid), .irq_prio(irq_prio), .err(err)
);

// File: tb/msi_pq_gate_bench.sv
module msi_pq_gate_bench;
  localparam int ADDR_W = 48;
  localparam int SRC_W  = 16;
  localparam int IRQ_W  = 20;
  localparam int NMEM   = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic c_en, c_large;
  logic [ADDR_W-1:0] c_base;
  logic [SRC_W:0] c_len, c_cnt;
  logic [IRQ_W-1:0] c_off;
  logic trig_valid, trig_ready, trig_force, trig_chk_owner;
  logic [ADDR_W-1:0] trig_addr;
  logic [15:0] trig_data, trig_owner;
  logic rd_valid, rd_ready, rsp_valid, wr_valid, wr_ready;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [63:0] rsp_data;
  logic [7:0] wr_data, irq_prio;
  logic irq_valid, err;
  logic [13:0] irq_server;
  logic [IRQ_W-1:0] irq_src;

  msi_pq_gate #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .IRQ_W(IRQ_W)) u_msi_pq_gate (
    .clk(clk), .rst_n(rst_n),
    .cfg_tbl_en(c_en), .cfg_tbl_base(c_base), .cfg_tbl_len(c_len), .cfg_large(c_large),
    .cfg_src_count(c_cnt), .cfg_src_offset(c_off),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_addr(trig_addr), .trig_data(trig_data),
    .trig_force(trig_force), .trig_chk_owner(trig_chk_owner), .trig_owner(trig_owner),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_valid(irq_valid), .irq_server(irq_server), .irq_src(irq_src), .irq_prio(irq_prio),
    .err(err)
  );

  int n_chk = 0, n_fail = 0;
  int exp_err = 0, err_seen = 0, coincide = 0;
  int pend_cnt = 0, pend_idx = 0;
  logic [63:0] phys [NMEM];
  logic [63:0] model [NMEM];
  logic [ADDR_W-1:0] q_rd_addr [$];
  int q_rd_idx [$];
  logic [ADDR_W-1:0] q_wr_addr [$];
  logic [7:0] q_wr_data [$];
  int q_wr_idx [$];
  logic [13:0] q_irq_srv [$];
  logic [IRQ_W-1:0] q_irq_src [$];
  logic [7:0] q_irq_prio [$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [15:0] srv, input logic [7:0] prio,
                                     input bit p, input bit q, input logic [1:0] gen,
                                     input logic [15:0] own);
    logic [63:0] e;
    e = '0;
    e[63:48] = srv; e[47:40] = prio; e[26:25] = gen; e[24] = p; e[16] = q; e[15:0] = own;
    return e;
  endfunction

  task automatic put(input int i, input logic [63:0] e);
    phys[i] = e; model[i] = e;
  endtask

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = phys[pend_idx];
      end
    end
    rd_ready = ($urandom % 4) != 0;
    wr_ready = ($urandom % 3) != 0;
    #1;
    if (rst_n) begin
      if (rd_valid && rd_ready) begin
        if (q_rd_addr.size() == 0) check("R2 R3 unexpected read", 64'(rd_addr), 64'hDEAD);
        else begin
          check("R4 entry read address", 64'(rd_addr), 64'(q_rd_addr.pop_front()));
          pend_idx = q_rd_idx.pop_front();
          pend_cnt = 1 + int'($urandom % 3);
        end
      end
      if (wr_valid && wr_ready) begin
        if (q_wr_addr.size() == 0) check("R5 R8 unexpected write", 64'(wr_addr), 64'hDEAD);
        else begin
          logic [ADDR_W-1:0] ea;
          int wi;
          ea = q_wr_addr.pop_front();
          wi = q_wr_idx.pop_front();
          check("R6 R7 R8 write address", 64'(wr_addr), 64'(ea));
          check("R6 R7 R8 write byte", 64'(wr_data), 64'(q_wr_data.pop_front()));
          if (ea[0]) phys[wi][23:16] = wr_data;
          else       phys[wi][31:24] = wr_data;
        end
      end
      if (irq_valid) begin
        if (trig_valid && trig_ready) coincide++;
        if (q_irq_srv.size() == 0) check("R6 R7 R8 unexpected irq", 64'(irq_src), 64'hDEAD);
        else begin
          check("R6 irq server", 64'(irq_server), 64'(q_irq_srv.pop_front()));
          check("R6 irq source", 64'(irq_src), 64'(q_irq_src.pop_front()));
          check("R6 irq priority", 64'(irq_prio), 64'(q_irq_prio.pop_front()));
        end
      end
      if (err) err_seen++;
    end
  end

  task automatic fire(input logic [15:0] hi, input logic [4:0] lo, input bit frc,
                      input bit chk, input logic [15:0] own);
    logic [15:0] s;
    logic [ADDR_W-1:0] ea;
    logic [63:0] e;
    logic [1:0] pq;
    logic [7:0] pb;
    s = hi | {11'b0, lo};
    @(negedge clk);
    trig_valid = 1'b1;
    trig_addr = {28'($urandom), hi, 4'($urandom)};
    trig_data = {11'($urandom), lo};
    trig_force = frc; trig_chk_owner = chk; trig_owner = own;
    if (!c_en || 17'(s) >= c_len || 17'(s) >= c_cnt) exp_err++;
    else begin
      ea = c_base + (c_large ? (ADDR_W'(s) * 128) : (ADDR_W'(s) * 16));
      q_rd_addr.push_back(ea); q_rd_idx.push_back(int'(s));
      e = model[s];
      if (chk && e[15:0] != own) exp_err++;
      else begin
        pq = frc ? 2'b00 : {e[24], e[16]};
        if (pq == 2'b00 && e[47:40] != 8'hFF) begin
          pb = {5'b0, e[26:25], 1'b1};
          q_wr_addr.push_back(ea + 4); q_wr_data.push_back(pb); q_wr_idx.push_back(int'(s));
          model[s][31:24] = pb;
          q_irq_srv.push_back(e[63:50]);
          q_irq_src.push_back(c_off + IRQ_W'(s));
          q_irq_prio.push_back(e[47:40]);
        end else if (pq == 2'b00 || pq == 2'b10) begin
          q_wr_addr.push_back(ea + 5); q_wr_data.push_back(8'h01); q_wr_idx.push_back(int'(s));
          model[s][23:16] = 8'h01;
        end
      end
    end
    #1;
    while (!trig_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (guard < 300 && !(trig_ready && q_rd_addr.size() == 0 && q_wr_addr.size() == 0 &&
                            q_irq_srv.size() == 0 && pend_cnt == 0)) begin
      @(negedge clk); #2; guard++;
    end
    repeat (3) @(negedge clk);
    check("R11 error pulse count", 64'(err_seen), 64'(exp_err));
    check("R10 outstanding work", 64'(q_rd_addr.size() + q_wr_addr.size() + q_irq_srv.size()), 64'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; trig_valid = 1'b0; trig_addr = '0; trig_data = '0;
    trig_force = 1'b0; trig_chk_owner = 1'b0; trig_owner = '0;
    rd_ready = 1'b0; wr_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    c_en = 1'b1; c_base = 48'h0000_4000_0000; c_len = 17'd40; c_cnt = 17'd48;
    c_large = 1'b0; c_off = 20'h01000;
    for (int i = 0; i < NMEM; i++)
      put(i, mk(16'($urandom), 8'h10, 1'b1, 1'b1, 2'($urandom), 16'($urandom % 4)));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 trig_ready after reset", 64'(trig_ready), 64'd1);
    check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    check("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    check("R1 irq_valid after reset", 64'(irq_valid), 64'd0);
    check("R1 err after reset", 64'(err), 64'd0);

    put(1, mk(16'h0abc, 8'h05, 1'b0, 1'b0, 2'b10, 16'h0007));
    put(2, mk(16'h1111, 8'hFF, 1'b0, 1'b0, 2'b01, 16'h0000));
    put(3, mk(16'h2222, 8'h07, 1'b0, 1'b1, 2'b00, 16'h0000));
    put(5, mk(16'h3334, 8'h02, 1'b0, 1'b0, 2'b11, 16'h0000));
    put(6, mk(16'h4448, 8'h03, 1'b0, 1'b0, 2'b01, 16'h1234));
    put(7, mk(16'h555c, 8'h03, 1'b0, 1'b0, 2'b01, 16'h0001));
    put(39, mk(16'h6660, 8'h01, 1'b0, 1'b0, 2'b00, 16'h0000));
    fire(16'd0, 5'd1, 1'b0, 1'b0, 16'h0);  // R6 set P and send
    fire(16'd0, 5'd1, 1'b0, 1'b0, 16'h0);  // R8 PQ=10 sets Q
    fire(16'd0, 5'd1, 1'b0, 1'b0, 16'h0);  // R8 PQ=11 drop
    fire(16'd0, 5'd1, 1'b1, 1'b0, 16'h0);  // R9 force sends again
    fire(16'd2, 5'd0, 1'b0, 1'b0, 16'h0);  // R7 masked
    fire(16'd1, 5'd2, 1'b0, 1'b0, 16'h0);  // R8 PQ=01 drop, R4 OR form gives 3
    fire(16'd5, 5'd5, 1'b0, 1'b0, 16'h0);  // R4 overlapping OR gives 5
    fire(16'd6, 5'd0, 1'b0, 1'b1, 16'h1234); // R5 owner match
    fire(16'd7, 5'd0, 1'b0, 1'b1, 16'h0002); // R5 owner mismatch
    drain();
    fire(16'd32, 5'd7, 1'b0, 1'b0, 16'h0);  // R3 src 39 in range
    fire(16'd40, 5'd0, 1'b0, 1'b0, 16'h0);  // R3 src 40 out of range
    drain();
    c_len = 17'd64; c_cnt = 17'd10;
    fire(16'd8, 5'd1, 1'b0, 1'b0, 16'h0);   // R3 src 9 ok
    fire(16'd8, 5'd2, 1'b0, 1'b0, 16'h0);   // R3 src 10 beyond count
    drain();
    c_en = 1'b0;
    fire(16'd0, 5'd1, 1'b1, 1'b0, 16'h0);   // R2 disabled table
    drain();
    c_en = 1'b1; c_large = 1'b1; c_cnt = 17'd64; c_base = 48'h0012_3456_7000;
    put(33, mk(16'h7fff, 8'h09, 1'b0, 1'b0, 2'b10, 16'h0));
    put(63, mk(16'h8004, 8'hFF, 1'b0, 1'b0, 2'b00, 16'h0));
    fire(16'd32, 5'd1, 1'b0, 1'b0, 16'h0);  // R4 large stride
    fire(16'd48, 5'd31, 1'b0, 1'b0, 16'h0); // R4 R7 last entry masked
    drain();
    c_large = 1'b0;
    for (int i = 20; i < 28; i++) put(i, mk(16'($urandom), 8'h03, 1'b0, 1'b0, 2'($urandom), 16'h0));
    for (int i = 20; i < 28; i++) fire(16'(i), 5'd0, 1'b0, 1'b0, 16'h0); // R10 back to back
    drain();
    check("R10 accept in interrupt cycle", 64'(coincide > 0), 64'd1);

    for (int r = 0; r < 25; r++) begin
      c_en = ($urandom % 10) != 0;
      c_len = 17'(1 + $urandom % 64);
      c_cnt = 17'(1 + $urandom % 64);
      c_large = 1'($urandom);
      c_base = 48'($urandom) << 8;
      c_off = 20'($urandom);
      for (int i = 0; i < NMEM; i++)
        put(i, mk(16'($urandom), (($urandom % 4) == 0) ? 8'hFF : 8'($urandom % 255),
                  1'($urandom), 1'($urandom), 2'($urandom), 16'($urandom % 4)));
      for (int k = 0; k < 12; k++)
        fire(16'($urandom % 64), 5'($urandom), ($urandom % 6) == 0, ($urandom % 3) == 0,
             16'($urandom % 4));
      drain();
    end
    summary();
    $finish;
  end
endmodule